// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block sits at the decode stage of a RISC-V-style scalar core and handles one instruction, the vector-length configuration instruction. That instruction carries an upper bound on the vector length in an immediate field and may take a source register. The block computes the resulting vector length from these. It writes that length into a destination scalar register through a register-file write port. It also remembers which scalar register now holds the vector length.

No separate length register is kept. The vector length lives in an ordinary scalar register, and a 5-bit pointer at decode names that register. A later instruction that reads the vector-length CSR is turned into a register move from the named register, so the pipeline never needs a real CSR for the length. While the pointer names x0, such a CSR read goes through untouched.

Out-of-range bounds and the reserved form of the encoding raise an illegal-instruction flag. The block is combinational from instruction to outputs. Only the pointer is a register, and it updates on the clock edge that ends the instruction's cycle.

Top module: `vlcfg_unit`

## Requirements
- R1: An instruction is a configuration instruction when instr_valid is 1, bits [6:0] equal 7'b1010111, bits [14:12] equal 3'b111 and bit 31 is 0. For such an instruction, bits [30:20] give the length bound, bits [19:15] the source register and bits [11:7] the destination register. An instruction with a different opcode or funct3 is not treated as a configuration instruction.
- R2: With the same opcode and funct3 but bit 31 equal to 1, the instruction is reserved: trap_illegal is 1, rf_we is 0 and the pointer keeps its value.
- R3: A configuration instruction whose bound is greater than XLEN sets trap_illegal, leaves rf_we at 0 and keeps the pointer. A bound equal to XLEN is legal.
- R4: When the source field is 0 (x0), the computed length equals the bound.
- R5: When the source field is not 0, the computed length is the unsigned minimum of rs1_rdata and the zero-extended bound.
- R6: A legal configuration instruction with a destination field other than 0 drives rf_we=1, rf_waddr equal to the destination field and rf_wdata equal to the computed length. With a destination of 0, rf_we stays 0.
- R7: After reset the pointer is 0. At the clock edge that ends a legal configuration instruction, the pointer takes that instruction's destination field.
- R8: A CSR read of the length, encoded as opcode 7'b1110011, funct3 3'b010, source 0 and CSR address VL_CSR (default 12'hC20), is rewritten while the pointer is not 0. instr_rewritten is then 1 and instr_out is {12'h000, pointer, 3'b000, rd, 7'b0010011}, which is a move from the pointed register into rd.
- R9: While the pointer is 0, such a CSR read leaves instr_out equal to instr with instr_rewritten at 0. Every other instruction also passes through unchanged, with instr_rewritten at 0.
- R10: While instr_valid is 0, trap_illegal, rf_we and instr_rewritten are 0 and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | The instruction word is valid this cycle |
| instr | input | 32 | Instruction word at decode |
| rs1_raddr | output | 5 | Register-file read address (source field) |
| rs1_rdata | input | XLEN | Register-file read data for rs1_raddr |
| trap_illegal | output | 1 | Illegal-instruction trap request |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | XLEN | Register-file write data (computed length) |
| instr_out | output | 32 | Instruction word forwarded to the pipeline |
| instr_rewritten | output | 1 | instr_out is a rewritten CSR read |

## Verification
The assertions watch four properties on every cycle. A trap never comes with a write, and no write targets x0. A written length never exceeds the bound. A rewritten word always names the current pointer and keeps the original rd. On top of that, the pointer stays put through traps and idle cycles and follows rd after a legal configuration. Whether the length is the correct minimum, and how the bound behaves at exactly XLEN and at XLEN plus one, can only be shown by the bench's scenarios. The same holds for a source value with its top bit set and for the pass-through behaviour after the pointer returns to x0. All of these depend on the specific values driven.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam logic [6:0] OPC_VCFG   = 7'b1010111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [2:0] F3_VCFG    = 3'b111;
  localparam logic [2:0] F3_CSRRS   = 3'b010;
  localparam logic [2:0] F3_ADDI    = 3'b000;

  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_CFG    = 2'd1,
    KIND_RSVD   = 2'd2,
    KIND_VLREAD = 2'd3
  } kind_e;

  // Field layout of the configuration instruction, MSB first
  typedef struct packed {
    logic        rsv;
    logic [10:0] bound;
    logic [4:0]  src;
    logic [2:0]  f3;
    logic [4:0]  dst;
    logic [6:0]  opc;
  } cfg_word_t;

  // ADDI dst, src, 0 : the register move that replaces a length read
  function automatic logic [31:0] make_move(input logic [4:0] dst,
                                            input logic [4:0] src);
    return {12'h000, src, F3_ADDI, dst, OPC_OPIMM};
  endfunction
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter logic [11:0] VL_CSR = 12'hC20
) (
  input  logic [31:0] instr,
  output kind_e       kind,
  output logic [10:0] bound,
  output logic [4:0]  src,
  output logic [4:0]  dst
);
  cfg_word_t w;
  logic      is_cfg_space;
  logic      is_vl_read;

  always_comb begin
    w            = cfg_word_t'(instr);
    is_cfg_space = (w.opc == OPC_VCFG) && (w.f3 == F3_VCFG);
    is_vl_read   = (w.opc == OPC_SYSTEM) && (w.f3 == F3_CSRRS) &&
                   (w.src == 5'd0) && (instr[31:20] == VL_CSR);
    if (is_cfg_space)
      kind = w.rsv ? KIND_RSVD : KIND_CFG;
    else if (is_vl_read)
      kind = KIND_VLREAD;
    else
      kind = KIND_OTHER;
    bound = w.bound;
    src   = w.src;
    dst   = w.dst;
  end
endmodule

// File: rtl/vlcfg_len.sv
module vlcfg_len #(
  parameter int XLEN = 64
) (
  input  logic [10:0]     bound,
  input  logic [4:0]      src,
  input  logic [XLEN-1:0] src_val,
  output logic [XLEN-1:0] vl,
  output logic            over
);
  localparam logic [11:0] LIMIT = 12'(XLEN);

  function automatic logic [XLEN-1:0] pick_len(input logic [10:0]     b,
                                               input logic              from_x0,
                                               input logic [XLEN-1:0]   v);
    logic [XLEN-1:0] bz;
    bz = XLEN'(b);
    if (from_x0)    return bz;
    else if (v < bz) return v;
    else            return bz;
  endfunction

  always_comb begin
    over = {1'b0, bound} > LIMIT;
    vl   = pick_len(bound, src == 5'd0, src_val);
  end
endmodule

// File: rtl/vlcfg_ptr.sv
module vlcfg_ptr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [4:0] next_ptr,
  output logic [4:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= 5'd0;
    else if (load)  ptr <= next_ptr;
  end
endmodule

// File: rtl/vlcfg_rewrite.sv
module vlcfg_rewrite
  import vlcfg_pkg::*;
(
  input  logic [31:0] instr_in,
  input  logic        vl_read,
  input  logic [4:0]  ptr,
  output logic [31:0] instr_out,
  output logic        rewritten
);
  always_comb begin
    rewritten = vl_read && (ptr != 5'd0);
    instr_out = rewritten ? make_move(instr_in[11:7], ptr) : instr_in;
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int          XLEN   = 64,
  parameter logic [11:0] VL_CSR = 12'hC20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  output logic [4:0]      rs1_raddr,
  input  logic [XLEN-1:0] rs1_rdata,
  output logic            trap_illegal,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic [31:0]     instr_out,
  output logic            instr_rewritten
);
  kind_e           kind;
  logic [10:0]     bound;
  logic [4:0]      src;
  logic [4:0]      dst;
  logic [XLEN-1:0] vl;
  logic            over;
  logic [4:0]      vl_ptr;
  logic            cfg_fire;
  logic            vl_read;

  vlcfg_decode #(.VL_CSR(VL_CSR)) u_dec (
    .instr (instr),
    .kind  (kind),
    .bound (bound),
    .src   (src),
    .dst   (dst)
  );

  vlcfg_len #(.XLEN(XLEN)) u_len (
    .bound   (bound),
    .src     (src),
    .src_val (rs1_rdata),
    .vl      (vl),
    .over    (over)
  );

  always_comb begin
    cfg_fire     = instr_valid && (kind == KIND_CFG) && !over;
    vl_read      = instr_valid && (kind == KIND_VLREAD);
    trap_illegal = instr_valid &&
                   ((kind == KIND_RSVD) || ((kind == KIND_CFG) && over));
    rf_we        = cfg_fire && (dst != 5'd0);
    rf_waddr     = dst;
    rf_wdata     = vl;
    rs1_raddr    = src;
  end

  vlcfg_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_fire),
    .next_ptr (dst),
    .ptr      (vl_ptr)
  );

  vlcfg_rewrite u_rw (
    .instr_in  (instr),
    .vl_read   (vl_read),
    .ptr       (vl_ptr),
    .instr_out (instr_out),
    .rewritten (instr_rewritten)
  );
endmodule

// File: rtl/vlcfg_unit_checker.sv
module vlcfg_unit_checker
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic            trap_illegal,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic [XLEN-1:0] rf_wdata,
  input logic [31:0]     instr_out,
  input logic            instr_rewritten,
  input logic [4:0]      vl_ptr,
  input logic            cfg_fire
);
  assert_trap_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_illegal |-> !rf_we);

  assert_no_x0_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != 5'd0) && !instr[31]);

  assert_len_within_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_wdata <= XLEN'(instr[30:20])));

  assert_rewrite_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_rewritten |-> (instr_out[19:15] == vl_ptr) && (vl_ptr != 5'd0) &&
                        (instr_out[11:7] == instr[11:7]) &&
                        (instr_out[6:0] == OPC_OPIMM) && (instr_out[14:12] == F3_ADDI) &&
                        (instr_out[31:20] == 12'h000) &&
                        (instr[6:0] == OPC_SYSTEM) && (instr[14:12] == F3_CSRRS));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !trap_illegal && !rf_we && !instr_rewritten);

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fire |=> $stable(vl_ptr));

  assert_ptr_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fire |=> (vl_ptr == $past(instr[11:7])));
endmodule

bind vlcfg_unit vlcfg_unit_checker #(.XLEN(XLEN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .instr_valid     (instr_valid),
  .instr           (instr),
  .trap_illegal    (trap_illegal),
  .rf_we           (rf_we),
  .rf_waddr        (rf_waddr),
  .rf_wdata        (rf_wdata),
  .instr_out       (instr_out),
  .instr_rewritten (instr_rewritten),
  .vl_ptr          (vl_ptr),
  .cfg_fire        (cfg_fire)
);

// File: tb/vlcfg_unit_test.sv
`timescale 1ns/1ps
module vlcfg_unit_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr = 32'h0;
  logic [4:0]      rs1_raddr;
  logic [XLEN-1:0] rs1_rdata = '0;
  logic            trap_illegal;
  logic            rf_we;
  logic [4:0]      rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic [31:0]     instr_out;
  logic            instr_rewritten;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vlcfg_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rs1_raddr(rs1_raddr), .rs1_rdata(rs1_rdata), .trap_illegal(trap_illegal),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .instr_out(instr_out), .instr_rewritten(instr_rewritten)
  );

  function automatic logic [31:0] enc_cfg(input logic b31, input int unsigned lim,
                                          input logic [4:0] s, input logic [4:0] d);
    return {b31, 11'(lim), s, 3'b111, d, 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_vlread(input logic [4:0] d);
    return {12'hC20, 5'd0, 3'b010, d, 7'b1110011};
  endfunction

  function automatic logic [31:0] enc_move(input logic [4:0] d, input logic [4:0] s);
    return {12'h000, s, 3'b000, d, 7'b0010011};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one instruction for one cycle; outputs settle before sampling
  task automatic present(input logic v, input logic [31:0] w, input logic [XLEN-1:0] src_val);
    @(negedge clk);
    instr_valid = v;
    instr       = w;
    rs1_rdata   = src_val;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
    instr       = 32'h0000_0013;
    #2;
  endtask

  // Read the pointer through the normal interface: a length CSR read
  task automatic expect_ptr(input string req, input logic [4:0] p);
    present(1'b1, enc_vlread(5'd9), '0);
    if (p == 5'd0) begin
      chk(req, {63'd0, instr_rewritten}, 64'd0);
      chk(req, {32'd0, instr_out}, {32'd0, enc_vlread(5'd9)});
    end else begin
      chk(req, {63'd0, instr_rewritten}, 64'd1);
      chk(req, {32'd0, instr_out}, {32'd0, enc_move(5'd9, p)});
    end
    idle();
  endtask

  task automatic t_reset();
    chk("R10 idle trap", {63'd0, trap_illegal}, 64'd0);
    chk("R10 idle write", {63'd0, rf_we}, 64'd0);
    expect_ptr("R7 reset pointer x0 / R9 passthrough", 5'd0);
  endtask

  task automatic t_x0_source();
    present(1'b1, enc_cfg(1'b0, 20, 5'd0, 5'd5), 64'hFFFF);
    chk("R1 recognised write", {63'd0, rf_we}, 64'd1);
    chk("R6 waddr", {59'd0, rf_waddr}, 64'd5);
    chk("R4 x0 source gives bound", rf_wdata, 64'd20);
    chk("R1 no trap", {63'd0, trap_illegal}, 64'd0);
    idle();
    expect_ptr("R8 rewrite from x5 / R7 follow", 5'd5);
  endtask

  task automatic t_min();
    present(1'b1, enc_cfg(1'b0, 32, 5'd3, 5'd6), 64'd10);
    chk("R5 min picks source", rf_wdata, 64'd10);
    present(1'b1, enc_cfg(1'b0, 32, 5'd3, 5'd6), 64'd100);
    chk("R5 min picks bound", rf_wdata, 64'd32);
    present(1'b1, enc_cfg(1'b0, 32, 5'd3, 5'd6), 64'h8000_0000_0000_0001);
    chk("R5 unsigned compare", rf_wdata, 64'd32);
    present(1'b1, enc_cfg(1'b0, 32, 5'd3, 5'd6), 64'd32);
    chk("R5 equal values", rf_wdata, 64'd32);
    idle();
    expect_ptr("R7 pointer x6", 5'd6);
  endtask

  task automatic t_bound_edge();
    present(1'b1, enc_cfg(1'b0, XLEN, 5'd0, 5'd7), '0);
    chk("R3 bound equal XLEN legal", {63'd0, trap_illegal}, 64'd0);
    chk("R3 bound equal XLEN value", rf_wdata, 64'(XLEN));
    present(1'b1, enc_cfg(1'b0, XLEN + 1, 5'd0, 5'd8), '0);
    chk("R3 bound over XLEN traps", {63'd0, trap_illegal}, 64'd1);
    chk("R3 no write on trap", {63'd0, rf_we}, 64'd0);
    present(1'b1, enc_cfg(1'b0, 2047, 5'd2, 5'd8), 64'd1);
    chk("R3 max bound traps", {63'd0, trap_illegal}, 64'd1);
    idle();
    expect_ptr("R3 pointer kept after trap", 5'd7);
  endtask

  task automatic t_reserved();
    present(1'b1, enc_cfg(1'b1, 10, 5'd0, 5'd12), '0);
    chk("R2 reserved traps", {63'd0, trap_illegal}, 64'd1);
    chk("R2 reserved no write", {63'd0, rf_we}, 64'd0);
    idle();
    expect_ptr("R2 pointer kept", 5'd7);
  endtask

  task automatic t_not_cfg();
    logic [31:0] w;
    w = enc_cfg(1'b0, 10, 5'd0, 5'd13);
    w[14:12] = 3'b110;
    present(1'b1, w, '0);
    chk("R1 other funct3 no write", {63'd0, rf_we}, 64'd0);
    chk("R9 other instr passthrough", {32'd0, instr_out}, {32'd0, w});
    chk("R9 not rewritten", {63'd0, instr_rewritten}, 64'd0);
    idle();
    expect_ptr("R1 pointer kept", 5'd7);
  endtask

  task automatic t_idle_valid_low();
    present(1'b0, enc_cfg(1'b0, 10, 5'd0, 5'd14), '0);
    chk("R10 invalid no write", {63'd0, rf_we}, 64'd0);
    chk("R10 invalid no trap", {63'd0, trap_illegal}, 64'd0);
    present(1'b0, enc_vlread(5'd4), '0);
    chk("R10 invalid no rewrite", {63'd0, instr_rewritten}, 64'd0);
    idle();
    expect_ptr("R10 pointer kept", 5'd7);
  endtask

  task automatic t_rd_x0();
    present(1'b1, enc_cfg(1'b0, 16, 5'd0, 5'd0), '0);
    chk("R6 rd x0 no write", {63'd0, rf_we}, 64'd0);
    chk("R6 rd x0 no trap", {63'd0, trap_illegal}, 64'd0);
    idle();
    expect_ptr("R9 pointer x0 passthrough", 5'd0);
  endtask

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_x0_source();
    t_min();
    t_bound_edge();
    t_reserved();
    t_not_cfg();
    t_idle_valid_low();
    t_rd_x0();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule